// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Aggregator

This block gathers 32 interrupt request lines into one status word and raises a single interrupt line toward a processor. Every source position is fixed at build time as either edge-sensitive or level-sensitive. A level position shows its synchronized input as it is now. An edge position is caught in a latch on a rising transition and stays there until software clears it.

Software reaches four registers through a small synchronous read/write port: the status word, an enable mask, the edge latch and a software-request register. Three edge positions can also be raised from software. The processor line is high whenever any enabled status bit is set. A companion index output names the lowest-numbered enabled pending source, so the dispatch routine can jump straight to the right handler.

A clear is written as a zero, not as a one. Software reads the latch, zeroes the bits it has serviced and writes the word back. Bits written as one keep their state, so a write can never create a pending edge.

Top module: `irqc_top`

## Requirements
- R1: After reset, the mask, edge-latch and software-request registers read zero. The interrupt line is low and the index output is 0.
- R2: The level positions are bits 0–15, 20, 21 and 25–27. Each shows its input in the status word (address 0) two clock edges after the input changes, and clears again when the input falls.
- R3: The edge positions are bits 16–19, 22–24 and 28–31. A rising transition of the synchronized input sets the latch bit, which stays set after the input falls.
- R4: A write to the edge latch (address 2) clears every bit written as 0 and leaves bits written as 1 unchanged. If a rising edge lands in the same cycle as a clear of that bit, the bit ends up set.
- R5: The software-request register (address 3) stores only bits 28–30. Other bits read 0 and have no effect. Its stored bits appear in the status word.
- R6: The interrupt line is high exactly when the status word ANDed with the mask register (address 1) is nonzero.
- R7: The index output is the lowest bit position set in status AND mask, and 0 when none is set.
- R8: A read has no side effect, and read data appears one cycle after the read strobe. A write to address 0 is ignored, and a write changes only the register it addresses.
- R9: Edge-latch bits at level positions always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt request lines |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 edge latch, 3 software request |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Processor interrupt line |
| irq_idx_o | output | 5 | Lowest enabled pending source |

## Verification
The hardest case to reach is a clear of a latch bit landing in the same cycle as a fresh rising edge on that bit. The bench counts the edges through the synchronizer and times its write so that it commits on the exact edge at which the latch would set. The rest of the stimulus is random source patterns held long enough to settle, mixed with random mask, clear and software writes. This makes the priority index move across groups and across edge and level positions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned ADDR_W = 2;
  localparam int unsigned GRP_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_LATCH  = 2'd2,
    REG_SOFT   = 2'd3
  } irqc_reg_e;

  // index of the lowest set bit in one group, 0 when empty
  function automatic logic [2:0] grp_lowest(input logic [GRP_W-1:0] v);
    logic [2:0] r;
    r = '0;
    for (int i = GRP_W - 1; i >= 0; i--) begin
      if (v[i]) r = 3'(i);
    end
    return r;
  endfunction

  // next edge-latch word: keep cleared bits cleared, set on new edges
  function automatic logic [31:0] latch_next(input logic [31:0] cur,
                                             input logic [31:0] keep,
                                             input logic [31:0] rise,
                                             input logic [31:0] emap);
    return ((cur & keep) | rise) & emap;
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter logic [31:0] EDGE_MAP = 32'hF1CF_0000,
  parameter logic [31:0] SOFT_MAP = 32'h7000_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] rise_i,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] soft_q,
  output logic [W-1:0] keep_o,
  output logic         wr_mask_o
);

  logic wr_latch, wr_soft;

  assign wr_mask_o = wr_i && (addr_i == REG_MASK);
  assign wr_latch  = wr_i && (addr_i == REG_LATCH);
  assign wr_soft   = wr_i && (addr_i == REG_SOFT);
  assign keep_o    = wr_latch ? wdata_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      latch_q <= '0;
      soft_q  <= '0;
    end else begin
      if (wr_mask_o) mask_q <= wdata_i;
      if (wr_soft)   soft_q <= wdata_i & W'(SOFT_MAP);
      latch_q <= W'(latch_next(32'(latch_q), 32'(keep_o), 32'(rise_i), EDGE_MAP));
    end
  end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     pend_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int unsigned NGRP = W / GRP_W;

  logic [NGRP-1:0] grp_any;
  logic [2:0]      grp_sub [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |pend_i[g*GRP_W +: GRP_W];
    assign grp_sub[g] = grp_lowest(pend_i[g*GRP_W +: GRP_W]);
  end

  always_comb begin
    idx_o = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_any[g]) idx_o = IDX_W'(g * GRP_W) + IDX_W'(grp_sub[g]);
    end
  end

  assign any_o = |grp_any;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] EDGE_MAP    = 32'hF1CF_0000,
  parameter logic [31:0] SOFT_MAP    = 32'h7000_0000,
  localparam int unsigned IDX_W      = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [NSRC-1:0]  bus_wdata_i,
  output logic [NSRC-1:0]  bus_rdata_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] irq_idx_o
);

  localparam logic [NSRC-1:0] EMAP = NSRC'(EDGE_MAP);

  logic [NSRC-1:0] sync_lvl, rise;
  logic [NSRC-1:0] mask_q, latch_q, soft_q, keep;
  logic [NSRC-1:0] status, pend;
  logic            wr_mask;

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(src_i), .sync_o(sync_lvl), .rise_o(rise)
  );

  irqc_regs #(.W(NSRC), .EDGE_MAP(EDGE_MAP), .SOFT_MAP(SOFT_MAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rise_i(rise), .mask_q(mask_q), .latch_q(latch_q),
    .soft_q(soft_q), .keep_o(keep), .wr_mask_o(wr_mask)
  );

  assign status = (sync_lvl & ~EMAP) | latch_q | soft_q;
  assign pend   = status & mask_q;

  irqc_prio #(.W(NSRC), .IDX_W(IDX_W)) u_prio (
    .pend_i(pend), .any_o(irq_o), .idx_o(irq_idx_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata_o <= '0;
    end else if (bus_rd_i) begin
      case (bus_addr_i)
        REG_STATUS: bus_rdata_o <= status;
        REG_MASK:   bus_rdata_o <= mask_q;
        REG_LATCH:  bus_rdata_o <= latch_q;
        default:    bus_rdata_o <= soft_q;
      endcase
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NSRC     = 32,
  parameter logic [31:0] SOFT_MAP = 32'h7000_0000,
  parameter logic [31:0] EDGE_MAP = 32'hF1CF_0000,
  localparam int unsigned IDX_W   = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_mask,
  input logic [NSRC-1:0]  keep,
  input logic [NSRC-1:0]  rise,
  input logic [NSRC-1:0]  latch_q,
  input logic [NSRC-1:0]  soft_q,
  input logic [NSRC-1:0]  mask_q,
  input logic [NSRC-1:0]  pend,
  input logic             irq_o,
  input logic [IDX_W-1:0] irq_idx_o
);

  logic [NSRC-1:0] below;
  assign below = ({{(NSRC-1){1'b0}}, 1'b1} << irq_idx_o) - 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && latch_q == '0 && soft_q == '0 && !irq_o)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(latch_q & keep) & ~latch_q) == '0)); // R4

  AST_LATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((latch_q & ~$past(latch_q)) & ~$past(rise)) == '0)); // R3

  AST_LATCH_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~NSRC'(EDGE_MAP)) == '0); // R9

  AST_SOFT_CONFINED: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_q & ~NSRC'(SOFT_MAP)) == '0); // R5

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend[irq_idx_o] && (pend & below) == '0)); // R7

  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_idx_o == '0 && pend == '0)); // R6

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R8

endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC), .SOFT_MAP(SOFT_MAP), .EDGE_MAP(EDGE_MAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .keep(keep), .rise(rise),
  .latch_q(latch_q), .soft_q(soft_q), .mask_q(mask_q), .pend(pend),
  .irq_o(irq_o), .irq_idx_o(irq_idx_o)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

  localparam logic [31:0] EDGE_BITS = 32'hF1CF_0000;
  localparam logic [31:0] SOFT_BITS = 32'h7000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic [4:0]  irq_idx_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_mask = '0, m_latch = '0, m_soft = '0;

  always #10 clk = ~clk;

  irqc_top dut (.*);

  function automatic logic [31:0] exp_status();
    return (src_i & ~EDGE_BITS) | m_latch | m_soft;
  endfunction

  function automatic int exp_idx(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  // drive sources, let them pass the synchronizer, update latch model (R3)
  task automatic drive_src(input logic [31:0] v);
    logic [31:0] old;
    old = src_i;
    @(negedge clk);
    src_i = v;
    repeat (4) @(negedge clk);
    m_latch |= EDGE_BITS & v & ~old;
  endtask

  task automatic check_out(input string tag);
    logic [31:0] p;
    p = exp_status() & m_mask;
    chk({tag, " R6 irq"}, {31'b0, irq_o}, {31'b0, p != 0});
    chk({tag, " R7 idx"}, {27'b0, irq_idx_o}, 32'(exp_idx(p)));
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(2'd0, d); chk({tag, " R2 status"}, d, exp_status());
    rd(2'd1, d); chk({tag, " R8 mask"}, d, m_mask);
    rd(2'd2, d); chk({tag, " R9 latch"}, d, m_latch);
    rd(2'd3, d); chk({tag, " R5 soft"}, d, m_soft);
    check_out(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_all("R1 reset");

    // R2 level follows input both ways
    wr(2'd1, 32'hFFFF_FFFF); m_mask = '1;
    drive_src(32'h0020_0001);
    check_all("R2 level high");
    drive_src(32'h0000_0000);
    check_all("R2 level low");

    // R3 edge latch persists after input falls
    drive_src(32'h0001_0000);
    drive_src(32'h0000_0000);
    check_all("R3 edge held");

    // R4 writing ones keeps, zeros clear
    drive_src(32'h8040_0000); drive_src('0);
    wr(2'd2, 32'hFFFF_FFFF);
    check_all("R4 ones keep");
    wr(2'd2, 32'hFFFE_FFFF); m_latch &= 32'hFFFE_FFFF;
    check_all("R4 zero clears");

    // R4 clear and new edge in the same cycle: edge wins
    @(negedge clk);
    src_i[17] = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = 2'd2; bus_wdata_i = 32'h0;
    @(negedge clk);
    bus_wr_i = 1'b0;
    m_latch = 32'h0002_0000;
    check_all("R4 race");
    drive_src('0);

    // R5 software request confined to its bits
    wr(2'd3, 32'hFFFF_FFFF); m_soft = SOFT_BITS;
    check_all("R5 soft set");
    wr(2'd3, 32'h0); m_soft = '0;

    // R8 write to status ignored, other registers untouched
    wr(2'd0, 32'h0);
    check_all("R8 status write");

    // R7 masked lower source does not win
    drive_src(32'h0000_0009);
    wr(2'd1, 32'h0000_0008); m_mask = 32'h0000_0008;
    check_all("R7 masked low");
    wr(2'd1, 32'h0); m_mask = '0;
    check_all("R6 all masked");

    // random mix
    for (int it = 0; it < 400; it++) begin
      drive_src($urandom & $urandom);
      case ($urandom_range(0, 3))
        0: begin d = $urandom; wr(2'd1, d); m_mask = d; end
        1: begin d = $urandom | $urandom; wr(2'd2, d); m_latch &= d; end
        2: begin d = $urandom; wr(2'd3, d); m_soft = d & SOFT_BITS; end
        default: begin d = $urandom; wr(2'd0, d); end
      endcase
      if (it % 8 == 0) check_all("rand R2 R3");
      else begin
        rd(2'd0, d); chk("rand R2 status", d, exp_status());
        check_out("rand");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule